// File: doc/BRIEF.md
# Two-Generation Write-Once Code Store

This block holds a small set of locations. Each location stores a 2-bit value as a 3-bit cell pattern whose bits may only go from 0 to 1. Because of this, a value can be rewritten without clearing the cells first. A blank location reads as value 00. The first change of value uses a single-weight pattern, and the second change uses a pattern of weight two or three. Each location also carries a generation flag. When a third distinct value arrives, the pattern is left unchanged and the block raises a one-cycle request for erase. It also marks the location as stale, which means it is treated as virtually erased. The actual clear is left to a separate agent, which drives the erase input.

A combinational read port returns, for any location, the stored pattern, the decoded value, the generation flag and the stale mark. Writes and erases each act on one location per clock cycle.

Top module: `wom_store`

## Requirements
- R1: After reset, every location holds pattern 000, reads value 00, has generation flag 0 and stale mark 0, and erase_needed is low.
- R2: Single-weight patterns decode with generation flag 0: 000 gives 00, 001 gives 01, 010 gives 10, 100 gives 11.
- R3: Patterns of weight two or more decode with generation flag 1: 111 gives 00, 110 gives 01, 101 gives 10, 011 gives 11.
- R4: A write of a value other than 00 to a location holding 000 stores that value's single-weight code and keeps generation flag 0.
- R5: A write of the value a location already decodes to changes nothing: pattern, flag and stale mark stay as they are, and erase_needed stays low.
- R6: A write of a different value to a location holding a nonzero single-weight pattern stores the bitwise complement of that value's single-weight code and sets generation flag 1.
- R7: A write of a different value to a location with generation flag 1 leaves its pattern unchanged and sets its stale mark. It also raises erase_needed for exactly the cycle after the write edge.
- R8: No write ever clears a bit of a stored pattern; old & ~new is always 000.
- R9: An erase request returns its location to pattern 000, generation flag 0 and stale mark 0 at the next edge.
- R10: If an erase and a write target the same location in the same cycle, the erase wins: the write is dropped and erase_needed stays low. If they target different locations, both take effect.
- R11: erase_needed is low in every cycle that does not follow an R7 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Location to write |
| wr_data | input | 2 | Value to write |
| ers_en | input | 1 | Erase request |
| ers_addr | input | AW | Location to erase |
| rd_addr | input | AW | Location to read |
| rd_data | output | 2 | Decoded value at rd_addr |
| rd_pattern | output | 3 | Stored cell pattern at rd_addr |
| rd_gen | output | 1 | Generation flag at rd_addr (0 first, 1 second) |
| rd_stale | output | 1 | Location awaits a physical erase |
| erase_needed | output | 1 | Pulse: the previous write needed an erase |

## Verification
The bench walks locations through every legal transition chain, so that all eight patterns appear on the read port. A decoder that mixed up the two code tables would return the wrong value at that point. Rewriting the held value is the trap for a design that compares patterns instead of values: such a design would move to the second generation or request an erase when it should not. The third distinct write must show an erase request in exactly one cycle with the pattern held, so an off-by-one pulse or a clobbered pattern is caught. The bench also sends an erase and a write to the same location in the same cycle, which exposes a design that lets the write win. A long random run is then compared cycle by cycle against a behavioural model.

// File: rtl/wom_store.sv
module wom_store #(
  parameter int LOCS = 8,
  localparam int AW = (LOCS > 1) ? $clog2(LOCS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [1:0]    wr_data,
  input  logic          ers_en,
  input  logic [AW-1:0] ers_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_data,
  output logic [2:0]    rd_pattern,
  output logic          rd_gen,
  output logic          rd_stale,
  output logic          erase_needed
);

  function automatic logic [2:0] first_code(input logic [1:0] d);
    case (d)
      2'd1:    first_code = 3'b001;
      2'd2:    first_code = 3'b010;
      2'd3:    first_code = 3'b100;
      default: first_code = 3'b000;
    endcase
  endfunction

  function automatic logic [1:0] decode(input logic [2:0] p);
    logic [2:0] q;
    q = ($countones(p) > 1) ? ~p : p;
    case (q)
      3'b001:  decode = 2'd1;
      3'b010:  decode = 2'd2;
      3'b100:  decode = 2'd3;
      default: decode = 2'd0;
    endcase
  endfunction

  logic [2:0] pat_q   [LOCS];
  logic       gen_q   [LOCS];
  logic       stale_q [LOCS];

  logic [2:0] cur_pat, nxt_pat;
  logic       cur_gen, collide, differ, wr_go, wr_apply, wr_block;

  assign cur_pat  = pat_q[wr_addr];
  assign cur_gen  = gen_q[wr_addr];
  assign collide  = ers_en && (ers_addr == wr_addr);
  assign wr_go    = wr_en && !collide;
  assign differ   = wr_data != decode(cur_pat);
  assign wr_apply = wr_go && differ && !cur_gen;
  assign wr_block = wr_go && differ && cur_gen;
  assign nxt_pat  = (cur_pat == 3'b000) ? first_code(wr_data) : ~first_code(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOCS; i++) begin
        pat_q[i]   <= 3'b000;
        gen_q[i]   <= 1'b0;
        stale_q[i] <= 1'b0;
      end
      erase_needed <= 1'b0;
    end else begin
      erase_needed <= wr_block;
      if (wr_apply) begin
        pat_q[wr_addr] <= nxt_pat;
        gen_q[wr_addr] <= (cur_pat != 3'b000);
      end
      if (wr_block) stale_q[wr_addr] <= 1'b1;
      if (ers_en) begin
        pat_q[ers_addr]   <= 3'b000;
        gen_q[ers_addr]   <= 1'b0;
        stale_q[ers_addr] <= 1'b0;
      end
    end
  end

  assign rd_pattern = pat_q[rd_addr];
  assign rd_data    = decode(rd_pattern);
  assign rd_gen     = gen_q[rd_addr];
  assign rd_stale   = stale_q[rd_addr];

endmodule

module wom_store_chk #(
  parameter int LOCS = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          ers_en,
  input logic [AW-1:0] ers_addr,
  input logic [2:0]    rd_pattern,
  input logic          rd_gen,
  input logic          erase_needed,
  input logic [2:0]    pat_q [LOCS],
  input logic          gen_q [LOCS]
);

  // R8
  bits_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(ers_en && ers_addr == wr_addr))
      |=> (($past(pat_q[wr_addr]) & ~pat_q[$past(wr_addr)]) == 3'b000));

  // R11
  erase_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_needed |-> ($past(wr_en) && !($past(ers_en) && $past(ers_addr) == $past(wr_addr))));

  // R7
  erase_keeps_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_needed |-> (pat_q[$past(wr_addr)] == $past(pat_q[wr_addr])));

  // R9
  erase_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ers_en |=> (pat_q[$past(ers_addr)] == 3'b000 && !gen_q[$past(ers_addr)]));

  // R3
  gen_matches_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gen == ($countones(rd_pattern) > 1));

endmodule

bind wom_store wom_store_chk #(.LOCS(LOCS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ers_en(ers_en), .ers_addr(ers_addr), .rd_pattern(rd_pattern),
  .rd_gen(rd_gen), .erase_needed(erase_needed), .pat_q(pat_q), .gen_q(gen_q)
);

// File: tb/test_wom_store.sv
module test_wom_store;
  localparam int LOCS = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, ers_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, ers_addr = '0, rd_addr = '0;
  logic [1:0] wr_data = '0;
  logic [1:0] rd_data;
  logic [2:0] rd_pattern;
  logic rd_gen, rd_stale, erase_needed;

  int total = 0, bad = 0;
  int m_pat [LOCS];
  int m_gen [LOCS];
  int m_stale [LOCS];
  int m_ers = 0;

  always #10 clk = ~clk;

  wom_store #(.LOCS(LOCS)) i_wom_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ers_en(ers_en), .ers_addr(ers_addr), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_pattern(rd_pattern), .rd_gen(rd_gen), .rd_stale(rd_stale),
    .erase_needed(erase_needed)
  );

  function automatic int code_a(int d);
    case (d)
      1: return 1;
      2: return 2;
      3: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int value_of(int p);
    for (int v = 0; v < 4; v++)
      if (p == code_a(v) || p == (7 - code_a(v))) return v;
    return -1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    int a;
    a = int'(rd_addr);
    chk(tag, "pattern", int'(rd_pattern), m_pat[a]);
    chk(tag, "value", int'(rd_data), value_of(m_pat[a]));
    chk(tag, "gen", int'(rd_gen), m_gen[a]);
    chk(tag, "stale", int'(rd_stale), m_stale[a]);
    chk(tag, "erase_needed", int'(erase_needed), m_ers);
  endtask

  task automatic cyc(string tag, bit we, int wa, int wd, bit ee, int ea, int ra);
    int v;
    wr_en = we; wr_addr = AW'(wa); wr_data = 2'(wd);
    ers_en = ee; ers_addr = AW'(ea); rd_addr = AW'(ra);
    @(posedge clk);
    m_ers = 0;
    if (we && !(ee && ea == wa)) begin
      v = value_of(m_pat[wa]);
      if (wd != v) begin
        if (m_gen[wa] == 1) begin
          m_ers = 1; m_stale[wa] = 1;
        end else if (m_pat[wa] == 0) begin
          m_pat[wa] = code_a(wd);
        end else begin
          m_pat[wa] = 7 - code_a(wd); m_gen[wa] = 1;
        end
      end
    end
    if (ee) begin
      m_pat[ea] = 0; m_gen[ea] = 0; m_stale[ea] = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(string tag, int a, int d);
    cyc(tag, 1'b1, a, d, 1'b0, 0, a);
  endtask

  task automatic idle(string tag, int ra);
    cyc(tag, 1'b0, 0, 0, 1'b0, 0, ra);
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < LOCS; i++) begin
      m_pat[i] = 0; m_gen[i] = 0; m_stale[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state on every location
    for (int i = 0; i < LOCS; i++) begin
      rd_addr = AW'(i); #1;
      compare("R1");
    end
    // R2 blank reads as 00 gen 0; R5 writing 00 to blank changes nothing
    wr("R5", 0, 0);
    // R4 first codes, then R2 decode of them
    wr("R4", 0, 1);  wr("R4", 1, 2);  wr("R4", 2, 3);  wr("R4", 3, 2);
    idle("R2", 0); idle("R2", 1); idle("R2", 2); idle("R2", 3);
    // R5 same-value rewrite in generation one
    wr("R5", 0, 1);
    // R6 second codes, R3 decode
    wr("R6", 0, 2);  wr("R6", 1, 3);  wr("R6", 2, 0);  wr("R6", 3, 1);
    idle("R3", 0); idle("R3", 1); idle("R3", 2); idle("R3", 3);
    // R5 same-value rewrite in generation two
    wr("R5", 0, 2);
    // R7 third distinct value: erase_needed pulse, pattern held, stale set
    wr("R7", 0, 3);
    idle("R11", 0);
    wr("R7", 0, 0);
    wr("R7", 0, 2);
    idle("R11", 0);
    // R9 erase clears location
    cyc("R9", 1'b0, 0, 0, 1'b1, 0, 0);
    wr("R4", 0, 3);
    // R10 collision: erase wins, write dropped
    cyc("R10", 1'b1, 1, 2, 1'b1, 1, 1);
    cyc("R10", 1'b1, 2, 1, 1'b1, 2, 2);
    // R10 different addresses both apply
    cyc("R10", 1'b1, 2, 2, 1'b1, 0, 2);
    idle("R10", 0);
    // R8 R11 random sweep against the model
    for (int n = 0; n < 600; n++) begin
      cyc("R11", 1'($urandom_range(0, 1)), int'($urandom_range(0, LOCS - 1)),
          int'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
          int'($urandom_range(0, LOCS - 1)), int'($urandom_range(0, LOCS - 1)));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule